// File: doc/BRIEF.md
# Address-Triggered Timestamp Recorder

This block watches the address bus of a processor under measurement and stores a timestamp each time the processor presents an address of interest. The target program needs no changes. A one-bit marker memory, indexed by the full snooped address, says which locations count. A host loads this memory through a small write port while the recorder is idle.

A run begins with an arm pulse. The arm pulse clears the 32-bit time base, the capture queue and both error flags. While the recorder is armed, every valid bus cycle whose address is marked pushes the time-base value from that bus cycle into a first-in first-out queue. A separate controller drains the queue through a show-ahead read port. A stop pulse ends the run.

Top module: `addr_stamp_rec`

## Requirements
- R1: After reset, `armed`, `cap_avail`, `ovf_err` and `mark_rej` are all 0.
- R2: A marker write (`mk_we`=1, with bit `mk_bit` stored at index `mk_addr`) takes effect only while `armed`=0. A write attempted while `armed`=1 leaves the marker unchanged and sets `mark_rej`, which stays set until the next arm.
- R3: A bus cycle with `bus_vld`=1 and a marked `bus_addr`, taken while `armed`=1, adds exactly one queue entry. That entry is visible on `cap_avail` at the second rising edge after the edge that samples the bus cycle.
- R4: No entry is added when the addressed marker is 0, when `bus_vld`=0, or when `armed`=0. A `stop` pulse clears `armed` at the next edge.
- R5: The time base reads 0 in the cycle after the arm edge and then rises by 1 every cycle. An entry holds the time-base value of the cycle in which its address was on the bus.
- R6: Back-to-back valid bus cycles to the same marked address each add their own entry, and their stamps differ by 1.
- R7: Entries leave the queue in arrival order. `cap_data` shows the oldest entry while `cap_avail`=1, and `cap_rd`=1 removes it at the clock edge.
- R8: When the queue already holds DEPTH entries, a new capture is dropped and `ovf_err` is set. `ovf_err` stays set until the next arm, and the stored entries are not changed.
- R9: An `arm` pulse sets `armed`, empties the queue, clears both flags and restarts the time base. The marker contents survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start-run pulse |
| stop | input | 1 | End-run pulse |
| bus_addr | input | ADDR_W | Snooped bus address |
| bus_vld | input | 1 | Bus address qualifier |
| mk_we | input | 1 | Marker write enable |
| mk_addr | input | ADDR_W | Marker write index |
| mk_bit | input | 1 | Marker value to write |
| cap_rd | input | 1 | Remove oldest entry |
| cap_data | output | TS_W | Oldest stored timestamp |
| cap_avail | output | 1 | Queue not empty |
| armed | output | 1 | Run in progress |
| ovf_err | output | 1 | Sticky: capture dropped on full queue |
| mark_rej | output | 1 | Sticky: marker write refused during run |

## Verification
A wrong marker bit shows up two cycles after the bus cycle: an entry appears or is missing on `cap_avail`. A time base that is off by one, or a stamp taken from the lookup cycle rather than the address cycle, shows up as a wrong `cap_data` value on the first hit after the arm. Corrupt queue pointers show up as reordered or repeated stamps when the queue is drained, and after an overflow the drain must stop at exactly DEPTH entries. A flag that is not cleared or not sticky is visible on its own port one cycle after the arm or after the offending event.

// File: rtl/addr_stamp_rec.sv
module addr_stamp_rec #(
  parameter int ADDR_W = 8,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stop,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_vld,
  input  logic              mk_we,
  input  logic [ADDR_W-1:0] mk_addr,
  input  logic              mk_bit,
  input  logic              cap_rd,
  output logic [TS_W-1:0]   cap_data,
  output logic              cap_avail,
  output logic              armed,
  output logic              ovf_err,
  output logic              mark_rej
);
  localparam int MARKS = 1 << ADDR_W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0]   FULL_CNT = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic            mark_mem [MARKS];
  logic            mark_q;
  logic            hit_vld_q;
  logic [TS_W-1:0] timer, ts_q;
  logic [TS_W-1:0] fifo_mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [PW:0]     cnt;

  wire capture = hit_vld_q & mark_q;
  wire full    = (cnt == FULL_CNT);
  wire push    = capture & ~full;
  wire pop     = cap_rd & (cnt != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  assign cap_data  = fifo_mem[rd_ptr];
  assign cap_avail = (cnt != '0);

  always_ff @(posedge clk) begin
    if (mk_we && !armed) mark_mem[mk_addr] <= mk_bit;
    mark_q <= mark_mem[bus_addr];
  end

  always_ff @(posedge clk) begin
    if (push && !arm) fifo_mem[wr_ptr] <= ts_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      timer     <= '0;
      hit_vld_q <= 1'b0;
      ts_q      <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      ovf_err   <= 1'b0;
      mark_rej  <= 1'b0;
    end else if (arm) begin
      armed     <= 1'b1;
      timer     <= '0;
      hit_vld_q <= 1'b0;
      ts_q      <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      ovf_err   <= 1'b0;
      mark_rej  <= 1'b0;
    end else begin
      if (stop) armed <= 1'b0;
      timer     <= timer + TS_W'(1);
      hit_vld_q <= bus_vld & armed;
      ts_q      <= timer;
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
      if (capture && full) ovf_err <= 1'b1;
      if (mk_we && armed)  mark_rej <= 1'b1;
    end
  end
endmodule

module addr_stamp_rec_chk #(
  parameter int ADDR_W = 8,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              stop,
  input logic              bus_vld,
  input logic              mk_we,
  input logic              cap_avail,
  input logic              armed,
  input logic              ovf_err,
  input logic              mark_rej
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !armed && !cap_avail && !ovf_err && !mark_rej);
  // R9
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) arm |=> armed && !cap_avail && !ovf_err && !mark_rej);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf_err && !arm |=> ovf_err);
  // R2
  rej_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) mark_rej && !arm |=> mark_rej);
  // R2
  rej_set_chk: assert property (@(posedge clk) disable iff (!rst_n) mk_we && armed && !arm |=> mark_rej);
  // R4
  stop_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n) stop && !arm |=> !armed);
  // R3
  entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cap_avail) |-> $past(bus_vld && armed, 2));
endmodule

bind addr_stamp_rec addr_stamp_rec_chk #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .bus_vld(bus_vld), .mk_we(mk_we),
  .cap_avail(cap_avail), .armed(armed), .ovf_err(ovf_err), .mark_rej(mark_rej)
);

// File: tb/addr_stamp_rec_bench.sv
module addr_stamp_rec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NVEC = 13;
  // {bus_vld, expected hit, address}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b11, 8'd2},   {2'b10, 8'd3},   {2'b11, 8'd9},   {2'b11, 8'd0},
    {2'b11, 8'd255}, {2'b11, 8'd100}, {2'b10, 8'd101}, {2'b11, 8'd16},
    {2'b11, 8'd254}, {2'b10, 8'd200}, {2'b10, 8'd5},   {2'b11, 8'd128},
    {2'b00, 8'd30}
  };

  logic clk = 0, rst_n = 0, arm = 0, stop = 0, bus_vld = 0, mk_we = 0, mk_bit = 0, cap_rd = 0;
  logic [7:0] bus_addr = 0, mk_addr = 0;
  logic [31:0] cap_data;
  logic cap_avail, armed, ovf_err, mark_rej;
  int total = 0, bad = 0;
  logic [31:0] cyc = 0, arm_cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  addr_stamp_rec #(.ADDR_W(8), .TS_W(32), .DEPTH(DEPTH)) u_addr_stamp_rec (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .bus_addr(bus_addr), .bus_vld(bus_vld),
    .mk_we(mk_we), .mk_addr(mk_addr), .mk_bit(mk_bit), .cap_rd(cap_rd), .cap_data(cap_data),
    .cap_avail(cap_avail), .armed(armed), .ovf_err(ovf_err), .mark_rej(mark_rej)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm();
    arm = 1; @(negedge clk); arm = 0; arm_cyc = cyc;
  endtask

  task automatic pop_one();
    cap_rd = 1; @(negedge clk); cap_rd = 0;
  endtask

  function automatic logic [31:0] now_ts();
    return cyc - arm_cyc;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 armed", armed, 0);
    check("R1 cap_avail", cap_avail, 0);
    check("R1 ovf_err", ovf_err, 0);
    check("R1 mark_rej", mark_rej, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {armed, cap_avail, ovf_err, mark_rej}, 0);

    // R2: load markers while idle (marked iff addr%7==2, or addr 0 or 255)
    for (int a = 0; a < 256; a++) begin
      mk_we = 1; mk_addr = 8'(a);
      mk_bit = (a % 7 == 2) || a == 0 || a == 255;
      @(negedge clk);
    end
    mk_we = 0;
    check("R2 no reject while idle", mark_rej, 0);

    do_arm();
    check("R9 armed after arm", armed, 1);

    // R3 R4 R5 R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_addr = VEC[i][7:0]; bus_vld = VEC[i][9]; t0 = now_ts();
      @(negedge clk); bus_vld = 0;
      @(negedge clk);
      check("R3/R4 capture presence", cap_avail, VEC[i][8]);
      if (VEC[i][8]) begin
        check("R5 stamp value", cap_data, t0);
        pop_one();
        check("R7 empty after pop", cap_avail, 0);
      end
    end

    // R2 rejected write while armed: address 3 unmarked, write 1
    mk_we = 1; mk_addr = 8'd3; mk_bit = 1; @(negedge clk); mk_we = 0;
    check("R2 reject flag", mark_rej, 1);
    bus_addr = 8'd3; bus_vld = 1; @(negedge clk); bus_vld = 0; @(negedge clk);
    check("R2 marker unchanged", cap_avail, 0);
    check("R2 reject sticky", mark_rej, 1);

    // R6 back-to-back same address
    bus_addr = 8'd2; bus_vld = 1; t0 = now_ts(); @(negedge clk); @(negedge clk); bus_vld = 0;
    @(negedge clk);
    check("R6 first stamp", cap_data, t0);
    pop_one();
    check("R6 second present", cap_avail, 1);
    check("R6 second stamp", cap_data, t0 + 1);
    pop_one();
    check("R6 drained", cap_avail, 0);

    // R8 overflow: DEPTH+1 consecutive hits
    bus_addr = 8'd9; bus_vld = 1; t0 = now_ts();
    repeat (DEPTH + 1) @(negedge clk);
    bus_vld = 0; @(negedge clk);
    check("R8 overflow flag", ovf_err, 1);
    for (int k = 0; k < DEPTH; k++) begin
      check("R8/R7 kept entry", cap_data, t0 + 32'(k));
      pop_one();
    end
    check("R8 extra dropped", cap_avail, 0);
    check("R8 flag sticky", ovf_err, 1);

    // R9 arm clears queue and flags, keeps markers, restarts time
    bus_addr = 8'd16; bus_vld = 1; @(negedge clk); bus_vld = 0; @(negedge clk);
    check("R9 entry before arm", cap_avail, 1);
    do_arm();
    check("R9 queue cleared", cap_avail, 0);
    check("R9 flags cleared", {ovf_err, mark_rej}, 0);
    repeat (3) @(negedge clk);
    bus_addr = 8'd255; bus_vld = 1; t0 = now_ts(); @(negedge clk); bus_vld = 0; @(negedge clk);
    check("R9 time restart", t0, 3);
    check("R9 marker kept", cap_avail, 1);
    check("R9 stamp after rearm", cap_data, 32'd3);
    pop_one();

    // R4 stop disarms; no capture afterwards
    stop = 1; @(negedge clk); stop = 0;
    check("R4 disarmed", armed, 0);
    bus_addr = 8'd2; bus_vld = 1; @(negedge clk); bus_vld = 0; @(negedge clk); @(negedge clk);
    check("R4 no capture when idle", cap_avail, 0);

    // R2 write accepted when idle again
    mk_we = 1; mk_addr = 8'd3; mk_bit = 1; @(negedge clk); mk_we = 0;
    check("R2 idle write no flag", mark_rej, 0);
    do_arm();
    bus_addr = 8'd3; bus_vld = 1; @(negedge clk); bus_vld = 0; @(negedge clk);
    check("R2 new marker active", cap_avail, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule